// File: doc/BRIEF.md
# Four-Key Ascending Sorter

This block accepts four unsigned keys at once and returns them ordered from smallest to largest. Its only building element is a compare-exchange cell: it takes two keys and puts the smaller on its low output and the larger on its high output. Five of these cells are arranged in three levels. The first level orders lanes 0/1 and lanes 2/3. The second level pairs the two low results with each other and the two high results with each other. After that, lane 0 holds the smallest key and lane 3 holds the largest. The third level is a single cell that places the two middle keys into lanes 1 and 2.

A valid flag travels alongside the keys. The parameter `PIPELINE` chooses between two forms. With 0 the sorter is purely combinational and the result appears in the same cycle. With 1 a register follows each level, so the result appears three cycles later. The key width is set by `W`. Lane i of both key buses occupies bits `[i*W +: W]`.

Top module: `sort4_net`

## Requirements
- R1: Whenever `out_vld` is 1, the output lanes are in non-decreasing order. Lane 0 holds the smallest input key and lane 3 holds the largest.
- R2: The four output keys are the same multiset as the four input keys that produced them. No key is lost, duplicated or altered.
- R3: All sixteen input patterns in which every key is 0 or 1 come out ordered, with the zeros in the low lanes.
- R4: When keys are equal they are not exchanged. Four identical inputs give that value on all four outputs.
- R5: With `PIPELINE`=1, `out_vld` equals `in_vld` from three clock cycles earlier. When it is 1, the keys on the output are the sorted form of the keys presented in that same earlier cycle.
- R6: With `PIPELINE`=0, `out_vld` follows `in_vld` and the sorted keys follow `in_keys` within the same cycle.
- R7: With `PIPELINE`=1, while `rst_n` is low, `out_vld` is 0 and every output key bit is 0.
- R8: With `PIPELINE`=1, in any cycle where `out_vld` is 0, `out_keys` keep the last sorted result. This holds even if the inputs change while `in_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the pipeline registers |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_vld | input | 1 | The four input keys are valid this cycle |
| in_keys | input | 4*W | Four unsigned keys, lane i at bits [i*W +: W] |
| out_vld | output | 1 | The four output keys are valid |
| out_keys | output | 4*W | Keys in ascending order, lane 0 smallest |

## Verification
The bench builds the block with a key width of 4. At that width all 65,536 four-key combinations can be streamed through one after another. This covers every ordering, every tie and every zero-one pattern with no sampling. Two copies are built side by side: one with `PIPELINE`=1, which exercises the three-cycle delay, bubbles in the valid stream and the hold behaviour, and one with `PIPELINE`=0, which exercises the same-cycle path.

// File: rtl/sort4_pkg.sv
package sort4_pkg;

  localparam int LANES  = 4;
  localparam int LEVELS = 3;

  // number of compare-exchange cells in a level (2 + 2 + 1 = 5)
  function automatic int cells_in(int lvl);
    return (lvl == LEVELS - 1) ? 1 : 2;
  endfunction

  // lane that receives the smaller key of cell c in level lvl
  function automatic int cell_lo(int lvl, int c);
    case (lvl)
      0:       return c * 2;
      1:       return c;
      default: return 1;
    endcase
  endfunction

  // lane that receives the larger key of cell c in level lvl
  function automatic int cell_hi(int lvl, int c);
    case (lvl)
      0:       return c * 2 + 1;
      1:       return c + 2;
      default: return 2;
    endcase
  endfunction

endpackage

// File: rtl/cmp_xchg.sv
module cmp_xchg #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi
);

  logic swap;

  // strict compare: equal keys pass straight through
  assign swap = (a > b);
  assign lo   = swap ? b : a;
  assign hi   = swap ? a : b;

endmodule

// File: rtl/sort_level.sv
module sort_level #(
  parameter int W   = 16,
  parameter int LVL = 0,
  parameter bit REG = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_vld,
  input  logic [sort4_pkg::LANES*W-1:0] in_keys,
  output logic                          out_vld,
  output logic [sort4_pkg::LANES*W-1:0] out_keys
);

  localparam int NC = sort4_pkg::cells_in(LVL);
  localparam int KW = sort4_pkg::LANES * W;

  logic [W-1:0]  c_lo [NC];
  logic [W-1:0]  c_hi [NC];
  logic [KW-1:0] nxt_keys;

  for (genvar c = 0; c < NC; c++) begin : g_cell
    cmp_xchg #(.W(W)) u_cx (
      .a  (in_keys[sort4_pkg::cell_lo(LVL, c)*W +: W]),
      .b  (in_keys[sort4_pkg::cell_hi(LVL, c)*W +: W]),
      .lo (c_lo[c]),
      .hi (c_hi[c])
    );
  end

  // lanes not touched by a cell of this level pass through
  always_comb begin
    nxt_keys = in_keys;
    for (int c = 0; c < NC; c++) begin
      nxt_keys[sort4_pkg::cell_lo(LVL, c)*W +: W] = c_lo[c];
      nxt_keys[sort4_pkg::cell_hi(LVL, c)*W +: W] = c_hi[c];
    end
  end

  if (REG) begin : g_reg
    logic          ld_en;
    logic          vld_q;
    logic [KW-1:0] keys_q;
    logic [KW-1:0] keys_d;

    assign ld_en = in_vld;

    always_comb begin
      keys_d = keys_q;
      if (ld_en) keys_d = nxt_keys;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q  <= 1'b0;
        keys_q <= '0;
      end else begin
        vld_q  <= in_vld;
        keys_q <= keys_d;
      end
    end

    assign out_vld  = vld_q;
    assign out_keys = keys_q;
  end else begin : g_comb
    assign out_vld  = in_vld;
    assign out_keys = nxt_keys;
  end

endmodule

// File: rtl/sort4_net.sv
module sort4_net #(
  parameter int W        = 16,
  parameter bit PIPELINE = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_vld,
  input  logic [sort4_pkg::LANES*W-1:0] in_keys,
  output logic                          out_vld,
  output logic [sort4_pkg::LANES*W-1:0] out_keys
);

  localparam int NL = sort4_pkg::LEVELS;
  localparam int KW = sort4_pkg::LANES * W;

  logic          rst_int_n;
  logic [NL:0]   vld_c;
  logic [KW-1:0] keys_c [NL+1];

  // reset: asserted at once, released after two clock edges
  if (PIPELINE) begin : g_rsync
    logic [1:0] sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= 2'b00;
      else        sync_q <= {sync_q[0], 1'b1};
    end
    assign rst_int_n = sync_q[1];
  end else begin : g_rdirect
    assign rst_int_n = rst_n;
  end

  assign vld_c[0]  = in_vld;
  assign keys_c[0] = in_keys;

  for (genvar g = 0; g < NL; g++) begin : g_lvl
    sort_level #(
      .W   (W),
      .LVL (g),
      .REG (PIPELINE)
    ) u_lvl (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .in_vld   (vld_c[g]),
      .in_keys  (keys_c[g]),
      .out_vld  (vld_c[g+1]),
      .out_keys (keys_c[g+1])
    );
  end

  assign out_vld  = vld_c[NL];
  assign out_keys = keys_c[NL];

endmodule

// File: rtl/sort4_chk.sv
module sort4_chk #(
  parameter int W        = 16,
  parameter bit PIPELINE = 1'b1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_vld,
  input logic [4*W-1:0] in_keys,
  input logic           out_vld,
  input logic [4*W-1:0] out_keys
);

  localparam int LAT = PIPELINE ? 3 : 0;

  logic           d_vld;
  logic [4*W-1:0] d_keys;
  logic [2:0]     age_q;
  logic           hist_ok;

  function automatic logic [W+1:0] key_sum(logic [4*W-1:0] k);
    logic [W+1:0] s;
    s = '0;
    for (int i = 0; i < 4; i++) s = s + (W+2)'(k[i*W +: W]);
    return s;
  endfunction

  function automatic logic [W-1:0] key_min(logic [4*W-1:0] k);
    logic [W-1:0] m;
    m = k[W-1:0];
    for (int i = 1; i < 4; i++) if (k[i*W +: W] < m) m = k[i*W +: W];
    return m;
  endfunction

  function automatic logic [W-1:0] key_max(logic [4*W-1:0] k);
    logic [W-1:0] m;
    m = k[W-1:0];
    for (int i = 1; i < 4; i++) if (k[i*W +: W] > m) m = k[i*W +: W];
    return m;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  age_q <= 3'd0;
    else if (age_q != 3'(LAT))   age_q <= age_q + 3'd1;
  end
  assign hist_ok = (age_q >= 3'(LAT));

  if (LAT > 0) begin : g_hist
    logic           vh [LAT];
    logic [4*W-1:0] kh [LAT];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < LAT; i++) begin
          vh[i] <= 1'b0;
          kh[i] <= '0;
        end
      end else begin
        vh[0] <= in_vld;
        kh[0] <= in_keys;
        for (int i = 1; i < LAT; i++) begin
          vh[i] <= vh[i-1];
          kh[i] <= kh[i-1];
        end
      end
    end
    assign d_vld  = vh[LAT-1];
    assign d_keys = kh[LAT-1];

    // R8
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q != 3'd0 && !out_vld) |-> $stable(out_keys));
  end else begin : g_nohist
    assign d_vld  = in_vld;
    assign d_keys = in_keys;
  end

  // R1
  sorted_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (out_keys[W-1:0]     <= out_keys[2*W-1:W]) &&
                (out_keys[2*W-1:W]   <= out_keys[3*W-1:2*W]) &&
                (out_keys[3*W-1:2*W] <= out_keys[4*W-1:3*W]));

  // R1
  min_max_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_ok && out_vld) |-> (out_keys[W-1:0] == key_min(d_keys)) &&
                             (out_keys[4*W-1:3*W] == key_max(d_keys)));

  // R2
  key_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_ok && out_vld) |-> key_sum(out_keys) == key_sum(d_keys));

  // R5 / R6
  vld_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hist_ok |-> out_vld == d_vld);

endmodule

bind sort4_net sort4_chk #(.W(W), .PIPELINE(PIPELINE)) i_sort4_chk (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .in_vld   (in_vld),
  .in_keys  (in_keys),
  .out_vld  (out_vld),
  .out_keys (out_keys)
);

// File: tb/test_sort4_net.sv
`timescale 1ns/1ps
module test_sort4_net;

  localparam int TW = 4;
  localparam int KW = 4 * TW;

  logic          clk;
  logic          rst_n;
  logic          in_vld;
  logic [KW-1:0] in_keys;
  logic          p_vld;
  logic [KW-1:0] p_keys;
  logic          c_vld;
  logic [KW-1:0] c_keys;

  int  n_tests;
  int  n_fail;
  int  step;
  bit  done;

  logic          hist_v [4];
  logic [KW-1:0] hist_k [4];
  string         hist_r [4];
  logic [KW-1:0] held_exp;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  sort4_net #(.W(TW), .PIPELINE(1'b1)) i_sort4_net (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_keys(in_keys),
    .out_vld(p_vld), .out_keys(p_keys)
  );

  sort4_net #(.W(TW), .PIPELINE(1'b0)) i_sort4_net_comb (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_keys(in_keys),
    .out_vld(c_vld), .out_keys(c_keys)
  );

  // ascending order built by counting occurrences of every value
  function automatic logic [KW-1:0] ref_sort(logic [KW-1:0] k);
    int cnt [16];
    int pos;
    logic [KW-1:0] r;
    for (int v = 0; v < 16; v++) cnt[v] = 0;
    for (int i = 0; i < 4; i++) cnt[k[i*TW +: TW]]++;
    pos = 0;
    r = '0;
    for (int v = 0; v < 16; v++)
      for (int j = 0; j < cnt[v]; j++) begin
        r[pos*TW +: TW] = TW'(v);
        pos++;
      end
    return r;
  endfunction

  task automatic check(string req, logic [KW-1:0] act, logic [KW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive_step(logic vld, logic [KW-1:0] keys, string req);
    int e;
    @(negedge clk);
    if (step >= 3) begin
      e = (step - 3) & 3;
      check({"R5 valid ", hist_r[e]}, KW'(p_vld), KW'(hist_v[e]));
      if (hist_v[e]) begin
        check({req == "" ? hist_r[e] : hist_r[e], " R5 keys"}, p_keys, ref_sort(hist_k[e]));
        held_exp = ref_sort(hist_k[e]);
      end else begin
        check("R8 hold", p_keys, held_exp);
      end
    end else begin
      check("R5 idle valid", KW'(p_vld), KW'(0));
    end
    in_vld  = vld;
    in_keys = keys;
    hist_v[step & 3] = vld;
    hist_k[step & 3] = keys;
    hist_r[step & 3] = req;
    #1;
    check("R6 valid", KW'(c_vld), KW'(vld));
    if (vld) check({req, " R6 keys"}, c_keys, ref_sort(keys));
    step++;
  endtask

  initial begin
    n_tests  = 0;
    n_fail   = 0;
    step     = 0;
    done     = 1'b0;
    held_exp = '0;
    rst_n    = 1'b0;
    in_vld   = 1'b1;
    in_keys  = 16'h3a5c;
    repeat (3) @(negedge clk);
    // R7: reset state of the pipelined copy
    check("R7 valid", KW'(p_vld), KW'(0));
    check("R7 keys", p_keys, '0);
    in_vld = 1'b0;
    rst_n  = 1'b1;
    repeat (5) @(negedge clk);

    // R3: every zero-one pattern
    for (int p = 0; p < 16; p++) begin
      logic [KW-1:0] k;
      for (int i = 0; i < 4; i++) k[i*TW +: TW] = TW'(p >> i & 1);
      drive_step(1'b1, k, "R3");
    end
    // R4: four identical keys
    for (int v = 0; v < 16; v++) drive_step(1'b1, {4{TW'(v)}}, "R4");
    // R1/R2: every four-key combination, with a bubble every fifth step
    for (int n = 0; n < 65536; n++) begin
      if (step % 5 == 4) drive_step(1'b0, KW'(n * 40503), "R8");
      drive_step(1'b1, KW'(n), "R1/R2");
    end
    // R8: idle with changing inputs after the stream
    for (int n = 0; n < 8; n++) drive_step(1'b0, KW'(n * 7919 + 123), "R8");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual step %0d expected completion", step);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule